// File: doc/BRIEF.md
# Indirect PHY configuration write port

This block gives a host write access to a bank of 8-bit PHY configuration registers through one 32-bit command register. The host writes a single word holding a write-enable flag, an 8-bit register address and an 8-bit value. The block latches the command and raises a request toward the PHY. The request holds until the PHY acknowledges it.

While the transfer is outstanding, bit 31 of the command register reads as 1. Software polls that bit before and after each command and gives up with an error once more than ten polls still show busy. A command written while busy is dropped, and a sticky flag records the loss. That flag clears when the register is read. Reading the register also returns the fields of the last command that was accepted.

Top module: `phy_cmd_port`

## Requirements
- R1: After reset, the read data is all zeros, phy_req_o is 0, and the overrun flag is clear.
- R2: While idle, a host write with bit 23 set is accepted. From the next cycle, bit 31 of the read data and phy_req_o are 1, phy_addr_o carries write bits 15:8 and phy_wdata_o carries write bits 7:0.
- R3: A host write with bit 23 clear starts no PHY access. Busy stays 0, the PHY register file is unchanged, and the readback fields keep their previous values.
- R4: While phy_req_o is high and phy_ack_i has not been sampled, phy_req_o, phy_addr_o and phy_wdata_o stay stable.
- R5: When phy_ack_i is sampled high with phy_req_o, both phy_req_o and read bit 31 are 0 from the next cycle.
- R6: A host write while busy is ignored. The target address and data do not change, and no PHY register is written by it.
- R7: A write while busy sets the overrun flag, which reads at bit 30. A read clears it, but a new overrun in the same cycle as the read keeps it set. The read that clears the flag still returns 1.
- R8: Read data bit 23 is 1 once any command has been accepted. Bits 15:8 and 7:0 are the address and data of the last accepted command. All other bits except 31 and 30 read 0, whatever was written to them.
- R9: With acknowledge delays of 1 to 20 cycles, every command completes within a poll budget of 11 polls spaced 4 cycles apart. After a sequence of commands, each PHY register holds the last value written to it. The bring-up sequence 0x00<-0x80, 0x01<-0x04, 0x68<-0xB4 lands as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe for the command register |
| host_wdata_i | input | 32 | Host write data: bit 23 write mode, 15:8 address, 7:0 data |
| host_rd_i | input | 1 | Host read strobe; clears the overrun flag |
| host_rdata_o | output | 32 | Readback: 31 busy, 30 overrun, 23 mode, 15:8 address, 7:0 data |
| phy_req_o | output | 1 | Request to the PHY register interface |
| phy_addr_o | output | 8 | PHY register address |
| phy_wdata_o | output | 8 | PHY register write data |
| phy_ack_i | input | 1 | PHY acknowledge |

## Verification
The bench builds the block with its default 8-bit address and 8-bit data fields, so the whole 256-entry PHY register space can be swept. Each address is written with a value computed from its index. A PHY model answers each request after a random 1 to 20 cycle delay, which covers the fastest turnaround as well as acknowledge delays near the poll budget. Directed cases use a fixed 20-cycle delay to hold the port busy. They cover overruns, the case of a read and an overrun in the same cycle, mode-clear writes and readback of junk bits.

// File: rtl/phy_cmd_pkg.sv
package phy_cmd_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned BUSY_BIT  = 31;
  localparam int unsigned OVR_BIT   = 30;
  localparam int unsigned MODE_BIT  = 23;
  localparam int unsigned ADDR_LSB  = 8;
  localparam int unsigned DATA_LSB  = 0;
  localparam int unsigned FIELD_W   = 8;

  typedef struct packed {
    logic               mode;
    logic [FIELD_W-1:0] addr;
    logic [FIELD_W-1:0] data;
  } phy_cmd_t;
endpackage

// File: rtl/phy_cmd_decode.sv
module phy_cmd_decode
  import phy_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = FIELD_W,
  parameter int unsigned DATA_W = FIELD_W
) (
  input  logic                 wr_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 busy_i,
  output logic                 accept_o,
  output logic                 overrun_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [DATA_W-1:0]    data_o
);
  logic mode;

  always_comb begin
    mode      = wdata_i[MODE_BIT];
    addr_o    = wdata_i[ADDR_LSB +: ADDR_W];
    data_o    = wdata_i[DATA_LSB +: DATA_W];
    accept_o  = wr_i && mode && !busy_i;
    overrun_o = wr_i && busy_i;
  end
endmodule

// File: rtl/phy_xfer_ctrl.sv
module phy_xfer_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              seen_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      seen_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      seen_o <= 1'b1;
      addr_o <= addr_i;
      data_o <= data_i;
    end else if (busy_o && ack_i) begin
      busy_o <= 1'b0;
    end
  end

  a_r2_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && addr_o == $past(addr_i) && data_o == $past(data_i));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ack_i) |=> busy_o && $stable(addr_o) && $stable(data_o));
  a_r5_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ack_i) |=> !busy_o);
endmodule

// File: rtl/phy_ovr_flag.sv
module phy_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a clearing read in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/phy_cmd_port.sv
module phy_cmd_port
  import phy_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = FIELD_W,
  parameter int unsigned DATA_W = FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [31:0]       host_wdata_i,
  input  logic              host_rd_i,
  output logic [31:0]       host_rdata_o,
  output logic              phy_req_o,
  output logic [ADDR_W-1:0] phy_addr_o,
  output logic [DATA_W-1:0] phy_wdata_o,
  input  logic              phy_ack_i
);
  logic              accept, overrun, busy, seen, ovr_flag;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;

  phy_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_i     (host_wr_i),
    .wdata_i  (host_wdata_i),
    .busy_i   (busy),
    .accept_o (accept),
    .overrun_o(overrun),
    .addr_o   (dec_addr),
    .data_o   (dec_data)
  );

  phy_xfer_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .addr_i (dec_addr),
    .data_i (dec_data),
    .ack_i  (phy_ack_i),
    .busy_o (busy),
    .seen_o (seen),
    .addr_o (phy_addr_o),
    .data_o (phy_wdata_o)
  );

  phy_ovr_flag u_ovr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (overrun),
    .clr_i (host_rd_i),
    .flag_o(ovr_flag)
  );

  assign phy_req_o = busy;

  always_comb begin
    host_rdata_o                        = '0;
    host_rdata_o[BUSY_BIT]              = busy;
    host_rdata_o[OVR_BIT]               = ovr_flag;
    host_rdata_o[MODE_BIT]              = seen;
    host_rdata_o[ADDR_LSB +: ADDR_W]    = phy_addr_o;
    host_rdata_o[DATA_LSB +: DATA_W]    = phy_wdata_o;
  end

  a_r3_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && !host_wdata_i[MODE_BIT] && !phy_req_o) |=> !phy_req_o);
  a_r6_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && phy_req_o && !phy_ack_i) |=> $stable(phy_addr_o) && $stable(phy_wdata_o));
  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && phy_req_o) |=> host_rdata_o[OVR_BIT]);
  a_r5_busy_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && phy_ack_i) |=> !host_rdata_o[BUSY_BIT]);
endmodule

// File: tb/phy_cmd_port_tb.sv
module phy_cmd_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        req, ack;
  logic [7:0]  paddr, pdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phy_cmd_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_wdata_i(wdata),
    .host_rd_i(rd), .host_rdata_o(rdata), .phy_req_o(req),
    .phy_addr_o(paddr), .phy_wdata_o(pdata), .phy_ack_i(ack)
  );

  // PHY model: register file with 1..20 cycle acknowledge delay
  logic [7:0] phy_mem [256];
  int fix_dly = 0;
  int cnt = 0, cur_dly = 1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; cnt <= 0; cur_dly <= 1;
      for (int i = 0; i < 256; i++) phy_mem[i] <= 8'h00;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (req) begin
      if (cnt + 1 >= cur_dly) begin
        ack <= 1'b1;
        phy_mem[paddr] <= pdata;
        cnt <= 0;
        cur_dly <= (fix_dly != 0) ? fix_dly : int'($urandom_range(20, 1));
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // R4/R5 protocol monitor, sampled at negedge
  logic       p_req = 0, p_ack = 0;
  logic [7:0] p_addr = 0, p_data = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (p_req && p_ack) begin
        chk("R5 req after ack", {31'd0, req}, 32'd0);
        chk("R5 busy after ack", {31'd0, rdata[31]}, 32'd0);
      end else if (p_req) begin
        chk("R4 req held", {31'd0, req}, 32'd1);
        chk("R4 addr/data held", {16'd0, paddr, pdata}, {16'd0, p_addr, p_data});
      end
    end
    p_req = req; p_ack = ack; p_addr = paddr; p_data = pdata;
  end

  task automatic host_write(input logic [31:0] w);
    @(negedge clk); wr = 1'b1; wdata = w;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic host_read(output logic [31:0] r);
    @(negedge clk); rd = 1'b1; r = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic poll_idle(input string tag);
    logic [31:0] r;
    bit ok = 0;
    for (int n = 0; n < 11 && !ok; n++) begin
      host_read(r);
      if (!r[31]) ok = 1;
      else repeat (2) @(negedge clk);
    end
    chk(tag, {31'd0, ok}, 32'd1);
  endtask

  task automatic cmd(input logic [7:0] a, input logic [7:0] d);
    poll_idle("R9 poll before");
    host_write({8'h00, 8'h80, a, d});
    poll_idle("R9 poll after");
  endtask

  logic [31:0] r;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 req", {31'd0, req}, 32'd0);

    // R2 + R8: junk bits, mode set, held with slow PHY
    fix_dly = 20;
    cmd(8'h05, 8'h06); // primes delay to 20
    host_write(32'h4F8A_3C5A);
    chk("R2 req", {31'd0, req}, 32'd1);
    chk("R2 addr", {24'd0, paddr}, 32'h3C);
    chk("R2 data", {24'd0, pdata}, 32'h5A);
    chk("R8 readback", rdata, 32'h8080_3C5A);

    // R6 + R7: write while busy
    host_write(32'h0080_1111);
    chk("R6 addr kept", {24'd0, paddr}, 32'h3C);
    chk("R6 data kept", {24'd0, pdata}, 32'h5A);
    host_read(r);
    chk("R7 flag set", {31'd0, r[30]}, 32'd1);
    host_read(r);
    chk("R7 flag cleared", {31'd0, r[30]}, 32'd0);
    // R7: read and overrun in same cycle
    @(negedge clk); rd = 1'b1; wr = 1'b1; wdata = 32'h0080_2222; r = rdata;
    @(negedge clk); rd = 1'b0; wr = 1'b0; wdata = '0;
    chk("R7 pre-read value", {31'd0, r[30]}, 32'd0);
    chk("R7 set beats clear", {31'd0, rdata[30]}, 32'd1);
    poll_idle("R9 poll directed");
    chk("R6 no stray write 11", {24'd0, phy_mem[8'h11]}, 32'h0);
    chk("R6 no stray write 22", {24'd0, phy_mem[8'h22]}, 32'h0);
    chk("R2 landed", {24'd0, phy_mem[8'h3C]}, 32'h5A);

    // R3: mode clear
    host_write(32'h0000_7777);
    chk("R3 no req", {31'd0, req}, 32'd0);
    chk("R3 readback kept", rdata & 32'hBFFF_FFFF, 32'h0080_3C5A);
    repeat (25) @(negedge clk);
    chk("R3 mem untouched", {24'd0, phy_mem[8'h77]}, 32'h0);

    // R9: exhaustive sweep with random delays
    fix_dly = 0;
    for (int a = 0; a < 256; a++) cmd(8'(a), 8'((a * 37 + 11) & 8'hFF));
    for (int a = 0; a < 256; a++)
      chk("R9 sweep", {24'd0, phy_mem[a]}, (a * 37 + 11) & 32'hFF);
    cmd(8'h00, 8'h80);
    cmd(8'h01, 8'h04);
    cmd(8'h68, 8'hB4);
    chk("R9 seq 00", {24'd0, phy_mem[8'h00]}, 32'h80);
    chk("R9 seq 01", {24'd0, phy_mem[8'h01]}, 32'h04);
    chk("R9 seq 68", {24'd0, phy_mem[8'h68]}, 32'hB4);
    chk("R8 last cmd", rdata, 32'h0080_68B4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule